// File: doc/BRIEF.md
# Stacked-Context Microsequencer

This block is the instruction sequencer of a small SIMD controller. It fetches 16-bit words from a 256-entry control store and decodes a 4-bit opcode, a 4-bit field that holds a condition selector, an immediate or a mask, and an 8-bit target address. The next program counter is chosen from the fall-through address, the target address or a saved return address. A separate condition evaluator judges the selected condition and returns a single global verdict.

The sequencer holds a small set of residual control registers. These are a 4-bit scratch-memory pointer, a 4-bit loop counter, a 4-bit lane-enable vector, and the 3-bit bus source and bus destination codes. The pointer, the counter and both bus codes live in a 16-level context stack next to the return addresses. The live values are copied into the current level on every cycle. A subroutine call therefore saves them without extra work. Per-register mask bits in the call decide whether each register keeps its live value or takes the value stored at the level being entered. A return restores all four registers and the return address from the level below.

A host fills the control store through a write port while reset is held. Execution starts at address 0 once reset is released.

Top module: `ctxseq_core`

## Requirements
- R1: While reset is active and after it is released, the PC is 0, the frame pointer is 0, the stack error flag is 0, all four lane enables are 1, and the pointer, counter, source and destination are 0. `instr_vld` is 0 during reset and in the first cycle after release, and the PC holds. The word at address 0 becomes valid one clock later.
- R2: An instruction word has the opcode in bits [15:12], the condition/immediate/mask field in [11:8] and the target in [7:0]. `instr_word` and `cond_sel` show the current word and its [11:8] field. Opcode 2 falls through to PC+1, which wraps modulo 256. Opcodes 8 to 15 jump to the target.
- R3: Opcode 4 loads the pointer from [11:8] and jumps to the target. Opcode 5 does the same for the counter.
- R4: Opcode 3 sets the source from [5:3] and the destination from [2:0], then falls through. When bit [6] is 1 it also loads the lane-enable vector from [11:8]; when bit [6] is 0 the enables are unchanged. In the enable vector, bit 3 is lane 0 and bit 0 is lane 3.
- R5: Opcode 1 jumps to the target when `cond_true` is 1. Otherwise it falls through to PC+1.
- R6: Opcode 6 applies its mask and then jumps to the target. Mask bit [11] increments the pointer modulo 16. Mask bit [10] rotates the enables so that new = {old[0], old[3:1]}. Mask bits [9] and [8] advance the source and destination codes only when the code names a lane (4 to 7), with 7 wrapping to 4. Codes 0 to 3 are left unchanged.
- R7: Opcode 7 saves PC+1 at the current level, increments the frame pointer and jumps to the target. Mask bits [11], [10], [9] and [8] cover the pointer, counter, source and destination. A set bit keeps the live value. A clear bit loads the value held at the new level.
- R8: Opcode 0 with `cond_true` at 1 decrements the frame pointer and resumes at the saved return address. It restores the pointer, counter, source and destination from the level below. With `cond_true` at 0 it jumps to the target.
- R9: A level holds the register values that were live in the last cycle in which it was current, including the cycle of the call that left it.
- R10: A call at frame pointer 15 sets the sticky error flag, keeps the pointer at 15 and the registers unchanged, and still jumps. A taken return at frame pointer 0 sets the flag, keeps the pointer at 0 and the registers unchanged, and falls through. Only reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Control-store write strobe |
| ld_addr | input | 8 | Control-store write address |
| ld_data | input | 16 | Control-store write data |
| cond_true | input | 1 | Global verdict for the condition shown on `cond_sel` |
| cond_sel | output | 4 | Field [11:8] of the current word |
| instr_word | output | 16 | Current instruction word |
| instr_vld | output | 1 | Current word is valid and executes this cycle |
| pc | output | 8 | Address of the current word |
| mar | output | 4 | Scratch-memory pointer |
| loop_ctr | output | 4 | Loop counter |
| proc_en | output | 4 | Lane enables, bit 3 = lane 0 |
| bus_src | output | 3 | Bus source code |
| bus_dst | output | 3 | Bus destination code |
| frame_ptr | output | 4 | Current stack level |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The per-cycle copy of live registers into the current level coincides with the call that moves the frame pointer. The register set chosen by the call mask must come from the level being entered, while the level being left captures that same cycle's live values. The bench provokes this by loading the counter and bus codes in the instruction just before a call with a mixed mask. It then returns twice and compares each restored register with the value that was live when that level was last current. A pop also coincides with the write of the level it leaves. The bench judges this through register values observed after a return, a re-call and a second return.

// File: rtl/ctxseq_pkg.sv
`timescale 1ns/1ps
package ctxseq_pkg;
    localparam int INSTR_W   = 16;
    localparam int CS_AW     = 8;
    localparam int NIB_W     = 4;
    localparam int BUS_W     = 3;
    localparam int LANES     = 4;
    localparam int STK_DEPTH = 16;
    localparam int FP_W      = $clog2(STK_DEPTH);

    localparam logic [3:0] OP_RET  = 4'h0;
    localparam logic [3:0] OP_BR   = 4'h1;
    localparam logic [3:0] OP_ALUF = 4'h2;
    localparam logic [3:0] OP_LBUS = 4'h3;
    localparam logic [3:0] OP_LMAR = 4'h4;
    localparam logic [3:0] OP_LCTR = 4'h5;
    localparam logic [3:0] OP_MOD  = 4'h6;
    localparam logic [3:0] OP_CALL = 4'h7;

    // Stacked residual registers
    typedef struct packed {
        logic [NIB_W-1:0] mar;
        logic [NIB_W-1:0] ctr;
        logic [BUS_W-1:0] src;
        logic [BUS_W-1:0] dst;
    } ctx_t;

    // Decoded instruction fields
    typedef struct packed {
        logic [3:0]       op;
        logic [NIB_W-1:0] fld;
        logic [CS_AW-1:0] tgt;
        logic             e_bit;
        logic [BUS_W-1:0] src;
        logic [BUS_W-1:0] dst;
    } dec_t;

    // Sequencer state
    typedef struct packed {
        logic             vld;
        logic [CS_AW-1:0] pc;
        ctx_t             ctx;
        logic [LANES-1:0] en;
        logic [FP_W-1:0]  fp;
        logic             err;
    } seq_t;

    // Advance a bus code only when it names a lane (top bit set), wrapping within lanes
    function automatic logic [BUS_W-1:0] lane_advance(input logic [BUS_W-1:0] code);
        logic [BUS_W-1:0] r;
        r = code;
        if (code[BUS_W-1]) r[BUS_W-2:0] = code[BUS_W-2:0] + 1'b1;
        return r;
    endfunction

    function automatic logic [LANES-1:0] en_rotate(input logic [LANES-1:0] v);
        return {v[0], v[LANES-1:1]};
    endfunction
endpackage

// File: rtl/ctxseq_cstore.sv
`timescale 1ns/1ps
module ctxseq_cstore #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];
    logic [DW-1:0] rdata_q;

    // Synchronous read, one cycle of latency
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/ctxseq_decode.sv
`timescale 1ns/1ps
module ctxseq_decode import ctxseq_pkg::*; (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               fields
);
    always_comb begin
        fields.op    = instr[15:12];
        fields.fld   = instr[11:8];
        fields.tgt   = instr[CS_AW-1:0];
        fields.e_bit = instr[6];
        fields.src   = instr[5:3];
        fields.dst   = instr[2:0];
    end
endmodule

// File: rtl/ctxseq_ctx_stack.sv
`timescale 1ns/1ps
module ctxseq_ctx_stack import ctxseq_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] cur_lvl,
    input  ctx_t                     cur_ctx,
    input  logic                     ret_we,
    input  logic [CS_AW-1:0]         ret_addr,
    output ctx_t                     up_ctx,
    output ctx_t                     dn_ctx,
    output logic [CS_AW-1:0]         dn_ret
);
    localparam int LW = $clog2(DEPTH);

    ctx_t             lvl_ctx [DEPTH];
    logic [CS_AW-1:0] lvl_ret [DEPTH];
    logic [LW-1:0]    up_lvl;
    logic [LW-1:0]    dn_lvl;

    assign up_lvl = cur_lvl + 1'b1;
    assign dn_lvl = cur_lvl - 1'b1;

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        ctx_t             ctx_q, ctx_d;
        logic [CS_AW-1:0] ret_q, ret_d;
        logic             sel;

        always_comb begin
            sel   = (cur_lvl == LW'(g));
            ctx_d = sel ? cur_ctx : ctx_q;            // live values shadow the current level
            ret_d = (sel && ret_we) ? ret_addr : ret_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctx_q <= '0;
                ret_q <= '0;
            end else begin
                ctx_q <= ctx_d;
                ret_q <= ret_d;
            end
        end

        assign lvl_ctx[g] = ctx_q;
        assign lvl_ret[g] = ret_q;
    end

    assign up_ctx = lvl_ctx[up_lvl];
    assign dn_ctx = lvl_ctx[dn_lvl];
    assign dn_ret = lvl_ret[dn_lvl];
endmodule

// File: rtl/ctxseq_core.sv
`timescale 1ns/1ps
module ctxseq_core import ctxseq_pkg::*; (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_we,
    input  logic [7:0]   ld_addr,
    input  logic [15:0]  ld_data,
    input  logic         cond_true,
    output logic [3:0]   cond_sel,
    output logic [15:0]  instr_word,
    output logic         instr_vld,
    output logic [7:0]   pc,
    output logic [3:0]   mar,
    output logic [3:0]   loop_ctr,
    output logic [3:0]   proc_en,
    output logic [2:0]   bus_src,
    output logic [2:0]   bus_dst,
    output logic [3:0]   frame_ptr,
    output logic         stack_err
);
    seq_t               st_q, st_d;
    logic [INSTR_W-1:0] ir;
    dec_t               dec;
    ctx_t               up_ctx, dn_ctx;
    logic [CS_AW-1:0]   dn_ret;
    logic [CS_AW-1:0]   pc_inc;
    logic               ret_wr;
    logic               at_top, at_bot;

    ctxseq_cstore #(.AW(CS_AW), .DW(INSTR_W)) u_cstore (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (st_d.pc),
        .rdata (ir)
    );

    ctxseq_decode u_decode (
        .instr  (ir),
        .fields (dec)
    );

    ctxseq_ctx_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_lvl  (st_q.fp),
        .cur_ctx  (st_q.ctx),
        .ret_we   (ret_wr),
        .ret_addr (pc_inc),
        .up_ctx   (up_ctx),
        .dn_ctx   (dn_ctx),
        .dn_ret   (dn_ret)
    );

    always_comb begin
        st_d   = st_q;
        ret_wr = 1'b0;
        pc_inc = st_q.pc + 1'b1;
        at_top = (st_q.fp == FP_W'(STK_DEPTH - 1));
        at_bot = (st_q.fp == '0);
        st_d.vld = 1'b1;

        if (st_q.vld) begin
            st_d.pc = pc_inc;
            case (dec.op)
                OP_RET: begin
                    if (cond_true) begin
                        if (at_bot) begin
                            st_d.err = 1'b1;
                        end else begin
                            st_d.fp  = st_q.fp - 1'b1;
                            st_d.ctx = dn_ctx;
                            st_d.pc  = dn_ret;
                        end
                    end else begin
                        st_d.pc = dec.tgt;
                    end
                end
                OP_BR: begin
                    if (cond_true) st_d.pc = dec.tgt;
                end
                OP_ALUF: begin
                    st_d.pc = pc_inc;
                end
                OP_LBUS: begin
                    if (dec.e_bit) st_d.en = dec.fld;
                    st_d.ctx.src = dec.src;
                    st_d.ctx.dst = dec.dst;
                end
                OP_LMAR: begin
                    st_d.ctx.mar = dec.fld;
                    st_d.pc      = dec.tgt;
                end
                OP_LCTR: begin
                    st_d.ctx.ctr = dec.fld;
                    st_d.pc      = dec.tgt;
                end
                OP_MOD: begin
                    if (dec.fld[3]) st_d.ctx.mar = st_q.ctx.mar + 1'b1;
                    if (dec.fld[2]) st_d.en      = en_rotate(st_q.en);
                    if (dec.fld[1]) st_d.ctx.src = lane_advance(st_q.ctx.src);
                    if (dec.fld[0]) st_d.ctx.dst = lane_advance(st_q.ctx.dst);
                    st_d.pc = dec.tgt;
                end
                OP_CALL: begin
                    st_d.pc = dec.tgt;
                    if (at_top) begin
                        st_d.err = 1'b1;
                    end else begin
                        ret_wr  = 1'b1;
                        st_d.fp = st_q.fp + 1'b1;
                        if (!dec.fld[3]) st_d.ctx.mar = up_ctx.mar;
                        if (!dec.fld[2]) st_d.ctx.ctr = up_ctx.ctr;
                        if (!dec.fld[1]) st_d.ctx.src = up_ctx.src;
                        if (!dec.fld[0]) st_d.ctx.dst = up_ctx.dst;
                    end
                end
                default: begin
                    st_d.pc = dec.tgt;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.en  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cond_sel   = dec.fld;
    assign instr_word = ir;
    assign instr_vld  = st_q.vld;
    assign pc         = st_q.pc;
    assign mar        = st_q.ctx.mar;
    assign loop_ctr   = st_q.ctx.ctr;
    assign proc_en    = st_q.en;
    assign bus_src    = st_q.ctx.src;
    assign bus_dst    = st_q.ctx.dst;
    assign frame_ptr  = st_q.fp;
    assign stack_err  = st_q.err;
endmodule

// File: rtl/ctxseq_core_chk.sv
`timescale 1ns/1ps
module ctxseq_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cond_true,
    input logic        instr_vld,
    input logic [15:0] instr_word,
    input logic [7:0]  pc,
    input logic [3:0]  mar,
    input logic [3:0]  frame_ptr,
    input logic        stack_err
);
    AST_HOLD_UNTIL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_vld |=> (pc == $past(pc))); // R1

    AST_LMAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && instr_word[15:12] == 4'h4)
        |=> (mar == $past(instr_word[11:8]) && pc == $past(instr_word[7:0]))); // R3

    AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && instr_word[15:12] == 4'h1 && cond_true)
        |=> (pc == $past(instr_word[7:0]))); // R5

    AST_BR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && instr_word[15:12] == 4'h1 && !cond_true)
        |=> (pc == 8'($past(pc) + 8'd1))); // R5

    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && instr_word[15:12] == 4'h7 && frame_ptr != 4'hF)
        |=> (frame_ptr == 4'($past(frame_ptr) + 4'd1) && pc == $past(instr_word[7:0]))); // R7

    AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && instr_word[15:12] == 4'h0 && cond_true && frame_ptr != 4'h0)
        |=> (frame_ptr == 4'($past(frame_ptr) - 4'd1))); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err); // R10
endmodule

bind ctxseq_core ctxseq_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_true  (cond_true),
    .instr_vld  (instr_vld),
    .instr_word (instr_word),
    .pc         (pc),
    .mar        (mar),
    .frame_ptr  (frame_ptr),
    .stack_err  (stack_err)
);

// File: tb/ctxseq_core_tb_top.sv
`timescale 1ns/1ps
module ctxseq_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        cond_true = 1'b0;
    logic [3:0]  cond_sel;
    logic [15:0] instr_word;
    logic        instr_vld;
    logic [7:0]  pc;
    logic [3:0]  mar, loop_ctr, proc_en, frame_ptr;
    logic [2:0]  bus_src, bus_dst;
    logic        stack_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ctxseq_core dut_i (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .cond_true(cond_true), .cond_sel(cond_sel), .instr_word(instr_word),
        .instr_vld(instr_vld), .pc(pc), .mar(mar), .loop_ctr(loop_ctr),
        .proc_en(proc_en), .bus_src(bus_src), .bus_dst(bus_dst),
        .frame_ptr(frame_ptr), .stack_err(stack_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        ld_we = 1'b0;
        cond_true = 1'b0;
        tick(1);
    endtask

    task automatic ld(input logic [7:0] a, input logic [15:0] d);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        tick(1);
        ld_we = 1'b0;
    endtask

    task automatic chk_ctx(input string req, input logic [3:0] m, input logic [3:0] c,
                           input logic [2:0] s, input logic [2:0] d);
        chk(req, "mar", 32'(mar), 32'(m));
        chk(req, "ctr", 32'(loop_ctr), 32'(c));
        chk(req, "src", 32'(bus_src), 32'(s));
        chk(req, "dst", 32'(bus_dst), 32'(d));
    endtask

    // Release reset and wait for the word at address 0
    task automatic go();
        chk("R1", "vld in reset", 32'(instr_vld), 0);
        chk("R1", "pc in reset", 32'(pc), 0);
        chk("R1", "fp in reset", 32'(frame_ptr), 0);
        chk("R1", "err in reset", 32'(stack_err), 0);
        chk("R1", "en in reset", 32'(proc_en), 32'hF);
        chk_ctx("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        chk("R1", "vld first cycle", 32'(instr_vld), 0);
        tick(1);
        chk("R1", "vld after fetch", 32'(instr_vld), 1);
        chk("R1", "pc start", 32'(pc), 0);
    endtask

    function automatic logic [2:0] adv(input logic [2:0] v);
        if (v < 3'd4) return v;
        return (v == 3'd7) ? 3'd4 : v + 3'd1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // ---------- Immediate loads and modify ----------
        hold_reset();
        ld(8'h00, 16'h4503); ld(8'h03, 16'h5907); ld(8'h07, 16'h3A6F);
        ld(8'h08, 16'h3011); ld(8'h09, 16'h6F20); ld(8'h20, 16'h3F7F);
        ld(8'h21, 16'h6330); ld(8'h30, 16'h4F31); ld(8'h31, 16'h6840);
        ld(8'h40, 16'h6240);
        go();
        chk("R2", "word at 0", 32'(instr_word), 32'h4503);
        tick(1); chk("R3", "lmar", 32'(mar), 5); chk("R3", "lmar pc", 32'(pc), 3);
        tick(1); chk("R3", "lctr", 32'(loop_ctr), 9); chk("R3", "lctr pc", 32'(pc), 7);
        tick(1); chk("R4", "en E=1", 32'(proc_en), 32'hA); chk("R4", "src", 32'(bus_src), 5);
                 chk("R4", "dst", 32'(bus_dst), 7); chk("R4", "pc", 32'(pc), 8);
        tick(1); chk("R4", "en kept E=0", 32'(proc_en), 32'hA); chk("R4", "src2", 32'(bus_src), 2);
                 chk("R4", "dst1", 32'(bus_dst), 1);
        tick(1); chk("R6", "mar inc", 32'(mar), 6); chk("R6", "rotate", 32'(proc_en), 5);
                 chk("R6", "src non-lane", 32'(bus_src), 2); chk("R6", "dst non-lane", 32'(bus_dst), 1);
                 chk("R6", "pc", 32'(pc), 32'h20);
        tick(1); tick(1);
        chk("R6", "src wrap", 32'(bus_src), 4); chk("R6", "dst wrap", 32'(bus_dst), 4);
        tick(1); tick(1); chk("R6", "mar wrap", 32'(mar), 0); chk("R6", "pc40", 32'(pc), 32'h40);
        tick(1); chk("R6", "src only", 32'(bus_src), 5); chk("R6", "dst held", 32'(bus_dst), 4);

        // ---------- Branch and sequencing ----------
        hold_reset();
        ld(8'h00, 16'h1310); ld(8'h10, 16'h1550); ld(8'h11, 16'h2ABC);
        ld(8'h12, 16'h9177); ld(8'h77, 16'hF0FF); ld(8'hFF, 16'h2000);
        go();
        chk("R2", "cond_sel", 32'(cond_sel), 3);
        cond_true = 1'b1; tick(1); chk("R5", "taken", 32'(pc), 32'h10);
        cond_true = 1'b0; tick(1); chk("R5", "fall", 32'(pc), 32'h11);
        tick(1); chk("R2", "op2 seq", 32'(pc), 32'h12);
        chk("R2", "word", 32'(instr_word), 32'h9177);
        tick(1); chk("R2", "op9 jump", 32'(pc), 32'h77);
        tick(1); chk("R2", "opF jump", 32'(pc), 32'hFF);
        tick(1); chk("R2", "pc wrap", 32'(pc), 0);

        // ---------- Call / return with masks ----------
        hold_reset();
        ld(8'h00, 16'h4301); ld(8'h01, 16'h5402); ld(8'h02, 16'h302E);
        ld(8'h03, 16'h7040); ld(8'h40, 16'h4741); ld(8'h41, 16'h7F80);
        ld(8'h80, 16'h5281); ld(8'h81, 16'h0190); ld(8'h90, 16'h0199);
        ld(8'h42, 16'h5B43); ld(8'h43, 16'h3035); ld(8'h44, 16'h7AC0);
        ld(8'hC0, 16'h0100); ld(8'h45, 16'h0100); ld(8'h04, 16'h0100);
        ld(8'h05, 16'h2000);
        go();
        cond_true = 1'b1;
        tick(3); chk_ctx("R3", 3, 4, 5, 6);
        tick(1); chk("R7", "fp", 32'(frame_ptr), 1); chk("R7", "pc", 32'(pc), 32'h40);
                 chk_ctx("R7", 0, 0, 0, 0);
        tick(2); chk("R7", "fp keep", 32'(frame_ptr), 2); chk_ctx("R7", 7, 0, 0, 0);
        tick(1); cond_true = 1'b0;
        tick(1); chk("R8", "not taken pc", 32'(pc), 32'h90); chk("R8", "fp held", 32'(frame_ptr), 2);
        cond_true = 1'b1;
        tick(1); chk("R8", "pop fp", 32'(frame_ptr), 1); chk("R8", "pop pc", 32'(pc), 32'h42);
                 chk_ctx("R9", 7, 0, 0, 0);
        tick(2); chk_ctx("R4", 7, 4'hB, 6, 5);
        tick(1); chk("R7", "mixed fp", 32'(frame_ptr), 2); chk_ctx("R9", 7, 2, 6, 0);
        tick(1); chk("R8", "pc45", 32'(pc), 32'h45); chk_ctx("R9", 7, 4'hB, 6, 5);
        tick(1); chk("R8", "fp0", 32'(frame_ptr), 0); chk("R8", "pc4", 32'(pc), 4);
                 chk_ctx("R9", 3, 4, 5, 6);
        chk("R10", "no err yet", 32'(stack_err), 0);
        tick(1); chk("R10", "underflow err", 32'(stack_err), 1); chk("R10", "fp floor", 32'(frame_ptr), 0);
                 chk("R10", "fall pc", 32'(pc), 5); chk_ctx("R10", 3, 4, 5, 6);
        tick(1); chk("R10", "sticky", 32'(stack_err), 1); chk("R10", "pc6", 32'(pc), 6);

        // ---------- Overflow ----------
        hold_reset();
        ld(8'h00, 16'h7F00);
        go();
        for (int i = 1; i < 16; i++) begin
            tick(1);
            chk("R7", "depth", 32'(frame_ptr), 32'(i));
            chk("R10", "no err", 32'(stack_err), 0);
        end
        tick(1);
        chk("R10", "overflow err", 32'(stack_err), 1);
        chk("R10", "fp ceiling", 32'(frame_ptr), 15);
        chk("R10", "still jumps", 32'(pc), 0);
        hold_reset();
        chk("R1", "err cleared", 32'(stack_err), 0);

        // ---------- Sweeps: bus-code advance and enable rotate ----------
        for (int s = 0; s < 8; s++) begin
            ld(8'(2*s),   {4'h3, 4'h0, 2'b00, 3'(s), 3'(s)});
            ld(8'(2*s+1), {4'h6, 4'b0011, 8'(2*s+2)});
        end
        for (int e = 0; e < 16; e++) begin
            ld(8'(16+2*e), {4'h3, 4'(e), 2'b01, 3'd0, 3'd0});
            ld(8'(17+2*e), {4'h6, 4'b0100, 8'(18+2*e)});
        end
        go();
        for (int s = 0; s < 8; s++) begin
            tick(2);
            chk("R6", "src sweep", 32'(bus_src), 32'(adv(3'(s))));
            chk("R6", "dst sweep", 32'(bus_dst), 32'(adv(3'(s))));
        end
        for (int e = 0; e < 16; e++) begin
            tick(2);
            chk("R6", "rot sweep", 32'(proc_en), 32'(((e >> 1) | ((e & 1) << 3))));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule